// File: doc/BRIEF.md
# Dual-Channel Line Reversal and Merge

This block rebuilds one left-to-right image line from a sensor whose horizontal shift register is read out from both ends at once. Each input beat carries one pixel from the left output and one from the right output. Each channel starts its row with a run of pixels that carry no image. First come empty stages, then light-shielded pixels, then guard pixels at the outer edge of the photosensitive area. The block discards that run on both channels. It keeps the active pixels of both channels in a pair of line slots used in turn. It then emits the line as a single stream: the left active pixels in arrival order, followed by the right active pixels in reverse arrival order. The right readout travels from the outer right edge toward the centre, so reversing it restores natural column order.

The input is a valid/ready stream. A beat transfers when `in_valid` and `in_ready` are both high. `in_sol` marks the first beat of a sensor row. The block lowers `in_ready` only when both line slots hold lines that have not yet been sent out. The output is a valid/ready stream that carries start-of-line and end-of-line markers. While `out_valid` is high and `out_ready` is low, the pixel and both markers stay unchanged. `ovf_err` is a sticky flag. It reports that a row start was offered while no line slot was free.

Top module: `dual_line_merge`

## Requirements
- R1: On each channel the first EMPTY_N+DARK_N+GUARD_N beats after a row start are discarded. The remaining ACT_N beats of the row are active pixels.
- R2: Each merged line begins with the ACT_N left-channel active pixels, in the order they arrived.
- R3: The left pixels are followed by the ACT_N right-channel active pixels in reverse arrival order: the last right pixel received comes first, the first right pixel received comes last.
- R4: A merged line is exactly 2*ACT_N output beats. `out_sol` is high only on the first beat and `out_eol` only on the last. Neither marker is high without `out_valid`.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_sol` and `out_eol` hold their values.
- R6: Two lines can be stored: a second row is accepted while the first has not been sent out. `in_ready` is low exactly while both slots hold unsent lines.
- R7: `ovf_err` rises in the cycle after a beat with `in_valid` and `in_sol` high is offered while `in_ready` is low. It stays high until reset and is never raised otherwise.
- R8: Input beats accepted outside a row (no row start seen since reset or since the previous row completed) are ignored and produce no output.
- R9: During and right after reset, `out_valid` is 0, `in_ready` is 1 and `ovf_err` is 0.
- R10: A row start accepted in the middle of a row restarts the row count. The unfinished row produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_sol | input | 1 | First beat of a sensor row |
| in_left | input | PIX_W | Pixel from the left readout channel |
| in_right | input | PIX_W | Pixel from the right readout channel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts output pixel |
| out_data | output | PIX_W | Merged line pixel |
| out_sol | output | 1 | First pixel of a merged line |
| out_eol | output | 1 | Last pixel of a merged line |
| ovf_err | output | 1 | Sticky: row start offered with both slots busy |

## Verification
The assertions assume that the upstream keeps its beats stable until `in_ready` accepts them, and that `out_ready` is driven as a plain level and is not a function of `out_valid`. The bench changes inputs only after the active edge and holds each offered beat until the handshake. It uses several downstream patterns: always ready, alternating, every third cycle stalled, and fully blocked to fill both slots. It also sends beats without a row start and a row that is cut off by a new start, so that both rule out stray output.

// File: rtl/merge_pkg.sv
package merge_pkg;
  // Number of leading beats per channel that carry no active image data
  function automatic int unsigned lead_len(int unsigned empty_n, int unsigned dark_n,
                                           int unsigned guard_n);
    return empty_n + dark_n + guard_n;
  endfunction

  // Total beats per channel row
  function automatic int unsigned row_len(int unsigned empty_n, int unsigned dark_n,
                                          int unsigned guard_n, int unsigned act_n);
    return empty_n + dark_n + guard_n + act_n;
  endfunction
endpackage

// File: rtl/lane_cropper.sv
module lane_cropper #(
  parameter int unsigned EMPTY_N = 12,
  parameter int unsigned DARK_N  = 28,
  parameter int unsigned GUARD_N = 16,
  parameter int unsigned ACT_N   = 2436,
  localparam int unsigned SKIP   = merge_pkg::lead_len(EMPTY_N, DARK_N, GUARD_N),
  localparam int unsigned ROW    = merge_pkg::row_len(EMPTY_N, DARK_N, GUARD_N, ACT_N),
  localparam int unsigned POS_W  = $clog2(ROW),
  localparam int unsigned IDX_W  = $clog2(ACT_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sol,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             row_done
);
  logic [POS_W-1:0] col_q;
  logic             in_row_q;
  logic [POS_W-1:0] pos;
  logic             live;
  logic [POS_W-1:0] rel;

  assign pos      = sol ? '0 : col_q;
  assign live     = beat & (sol | in_row_q);
  assign rel      = pos - POS_W'(SKIP);
  assign wr_en    = live & (pos >= POS_W'(SKIP));
  assign wr_idx   = IDX_W'(rel);
  assign row_done = live & (pos == POS_W'(ROW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q    <= '0;
      in_row_q <= 1'b0;
    end else if (live) begin
      if (pos == POS_W'(ROW - 1)) begin
        col_q    <= '0;
        in_row_q <= 1'b0;
      end else begin
        col_q    <= pos + POS_W'(1);
        in_row_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/line_ram.sv
module line_ram #(
  parameter int unsigned PIX_W = 12,
  parameter int unsigned DEPTH = 2436,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [PIX_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [PIX_W-1:0] rdata
);
  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/drain_seq.sv
module drain_seq #(
  parameter int unsigned ACT_N = 2436,
  localparam int unsigned TOT  = 2 * ACT_N,
  localparam int unsigned CNT_W = $clog2(TOT),
  localparam int unsigned IDX_W = $clog2(ACT_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_full,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_sol,
  output logic             out_eol,
  output logic             rd_slot,
  output logic             rd_right,
  output logic [IDX_W-1:0] rd_idx,
  output logic             drain_done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             slot_q;
  logic             fire;
  logic [CNT_W-1:0] back;

  assign out_valid  = slot_full;
  assign fire       = out_valid & out_ready;
  assign out_sol    = out_valid & (cnt_q == '0);
  assign out_eol    = out_valid & (cnt_q == LAST);
  assign rd_slot    = slot_q;
  assign rd_right   = cnt_q >= CNT_W'(ACT_N);
  assign back       = LAST - cnt_q;
  assign rd_idx     = rd_right ? IDX_W'(back) : IDX_W'(cnt_q);
  assign drain_done = fire & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= 1'b0;
    end else if (fire) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        slot_q <= ~slot_q;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/dual_line_merge.sv
module dual_line_merge #(
  parameter int unsigned PIX_W   = 12,
  parameter int unsigned EMPTY_N = 12,
  parameter int unsigned DARK_N  = 28,
  parameter int unsigned GUARD_N = 16,
  parameter int unsigned ACT_N   = 2436,
  localparam int unsigned IDX_W  = $clog2(ACT_N),
  localparam int unsigned SLOTS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sol,
  input  logic [PIX_W-1:0] in_left,
  input  logic [PIX_W-1:0] in_right,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_sol,
  output logic             out_eol,
  output logic             ovf_err
);
  logic [SLOTS-1:0] full_q;
  logic             wr_slot_q;
  logic             ovf_q;
  logic             beat;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             row_done;
  logic             rd_slot;
  logic             rd_right;
  logic [IDX_W-1:0] rd_idx;
  logic             drain_done;
  logic [PIX_W-1:0] left_q  [SLOTS];
  logic [PIX_W-1:0] right_q [SLOTS];

  assign in_ready = ~full_q[wr_slot_q];
  assign beat     = in_valid & in_ready;
  assign ovf_err  = ovf_q;

  lane_cropper #(
    .EMPTY_N(EMPTY_N), .DARK_N(DARK_N), .GUARD_N(GUARD_N), .ACT_N(ACT_N)
  ) u_crop (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sol(in_sol),
    .wr_en(wr_en), .wr_idx(wr_idx), .row_done(row_done)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en & (wr_slot_q == 1'(g));

    line_ram #(.PIX_W(PIX_W), .DEPTH(ACT_N)) u_left (
      .clk(clk), .we(slot_we), .waddr(wr_idx), .wdata(in_left),
      .raddr(rd_idx), .rdata(left_q[g])
    );
    line_ram #(.PIX_W(PIX_W), .DEPTH(ACT_N)) u_right (
      .clk(clk), .we(slot_we), .waddr(wr_idx), .wdata(in_right),
      .raddr(rd_idx), .rdata(right_q[g])
    );
  end

  drain_seq #(.ACT_N(ACT_N)) u_drain (
    .clk(clk), .rst_n(rst_n), .slot_full(full_q[rd_slot]), .out_ready(out_ready),
    .out_valid(out_valid), .out_sol(out_sol), .out_eol(out_eol),
    .rd_slot(rd_slot), .rd_right(rd_right), .rd_idx(rd_idx), .drain_done(drain_done)
  );

  assign out_data = rd_right ? right_q[rd_slot] : left_q[rd_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q    <= '0;
      wr_slot_q <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      if (row_done) begin
        full_q[wr_slot_q] <= 1'b1;
        wr_slot_q         <= ~wr_slot_q;
      end
      if (drain_done) full_q[rd_slot] <= 1'b0;
      if (in_valid & in_sol & ~in_ready) ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dual_line_merge_chk.sv
module dual_line_merge_chk #(
  parameter int unsigned PIX_W = 12,
  parameter int unsigned ACT_N = 2436
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_sol,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_data,
  input logic             out_sol,
  input logic             out_eol,
  input logic             ovf_err
);
  int unsigned beat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) beat_cnt <= 0;
    else if (out_valid && out_ready) beat_cnt <= out_eol ? 0 : beat_cnt + 1;
  end

  a_r5_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sol) && $stable(out_eol));

  a_r4_sol_first: assert property (@(posedge clk) disable iff (!rst_n)
    out_sol |-> beat_cnt == 0);

  a_r4_eol_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol |-> beat_cnt == 2 * ACT_N - 1);

  a_r4_marks_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_sol && !out_eol);

  a_r4_eol_seen: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && beat_cnt == 2 * ACT_N - 1 |-> out_eol);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  a_r7_raise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sol && !in_ready |=> ovf_err);

  a_r7_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_err) |-> $past(in_valid && in_sol && !in_ready));
endmodule

bind dual_line_merge dual_line_merge_chk #(.PIX_W(PIX_W), .ACT_N(ACT_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_sol(in_sol),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sol(out_sol), .out_eol(out_eol), .ovf_err(ovf_err)
);

// File: tb/test_dual_line_merge.sv
`timescale 1ns/1ps
module test_dual_line_merge;
  localparam int PIX_W   = 12;
  localparam int EMPTY_N = 2;
  localparam int DARK_N  = 3;
  localparam int GUARD_N = 2;
  localparam int ACT_N   = 5;
  localparam int SKIP    = EMPTY_N + DARK_N + GUARD_N;
  localparam int ROW     = SKIP + ACT_N;
  localparam int TOT     = 2 * ACT_N;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic             in_sol = 1'b0;
  logic [PIX_W-1:0] in_left = '0;
  logic [PIX_W-1:0] in_right = '0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [PIX_W-1:0] out_data;
  logic             out_sol;
  logic             out_eol;
  logic             ovf_err;

  int total = 0;
  int bad = 0;
  int rdy_mode = 0;
  int cyc = 0;
  int mon_idx = 0;
  bit finished = 0;
  int exp_q[$];
  bit prev_stall = 0;
  logic [PIX_W-1:0] prev_data = '0;

  always #2.5 clk = ~clk;

  dual_line_merge #(.PIX_W(PIX_W), .EMPTY_N(EMPTY_N), .DARK_N(DARK_N),
                    .GUARD_N(GUARD_N), .ACT_N(ACT_N)) i_dual_line_merge (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_sol(in_sol),
    .in_left(in_left), .in_right(in_right), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sol(out_sol), .out_eol(out_eol), .ovf_err(ovf_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lval(int seed, int pos);
    return seed * 32 + pos;
  endfunction

  function automatic int rval(int seed, int pos);
    return 2048 + seed * 32 + pos;
  endfunction

  // called at posedge+1; returns at posedge+1 after the handshake edge
  task automatic put_beat(input bit s, input int l, input int r);
    in_valid = 1'b1;
    in_sol   = s;
    in_left  = PIX_W'(l);
    in_right = PIX_W'(r);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_sol   = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // R1 R2 R3: expected merged line computed from the row contents
  task automatic send_row(input int seed, input int gap, input int nbeats);
    if (nbeats == ROW) begin
      for (int p = SKIP; p < ROW; p++) exp_q.push_back(lval(seed, p));
      for (int p = ROW - 1; p >= SKIP; p--) exp_q.push_back(rval(seed, p));
    end
    for (int p = 0; p < nbeats; p++) begin
      put_beat(p == 0, lval(seed, p), rval(seed, p));
      idle(gap);
    end
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    idle(3);
  endtask

  // downstream ready patterns
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      case (rdy_mode)
        0: out_ready = 1'b1;
        1: out_ready = cyc[0];
        2: out_ready = 1'b0;
        default: out_ready = (cyc % 3) != 0;
      endcase
    end
  end

  // monitor: scoreboard compare, markers and stall hold
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall) begin
          check(out_valid && out_data == prev_data, "R5 hold under stall", int'(out_data), int'(prev_data));
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R8 unexpected output beat", int'(out_data), -1);
          end else begin
            int e;
            e = exp_q.pop_front();
            check(int'(out_data) == e, mon_idx < ACT_N ? "R2 left pixel" : "R3 right reversed pixel",
                  int'(out_data), e);
          end
          check(out_sol == (mon_idx == 0), "R4 sol marker", int'(out_sol), int'(mon_idx == 0));
          check(out_eol == (mon_idx == TOT - 1), "R4 eol marker", int'(out_eol), int'(mon_idx == TOT - 1));
          mon_idx = (mon_idx == TOT - 1) ? 0 : mon_idx + 1;
        end
      end else begin
        prev_stall = 0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R9 reset in_ready", int'(in_ready), 1);
    check(ovf_err == 1'b0, "R9 reset ovf_err", int'(ovf_err), 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R9 after reset", int'(out_valid), 0);
    @(posedge clk);
    #1;

    // R8: beats without a row start are ignored
    for (int k = 0; k < ROW + 3; k++) put_beat(1'b0, 100 + k, 200 + k);
    idle(4);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 orphan beats produce nothing", int'(out_valid), 0);
    @(posedge clk);
    #1;

    // R1 R2 R3 R4: full speed, back to back rows
    rdy_mode = 0;
    send_row(1, 0, ROW);
    send_row(2, 0, ROW);
    wait_drain();

    // R5: alternating ready with input gaps
    rdy_mode = 1;
    send_row(3, 1, ROW);
    send_row(4, 0, ROW);
    wait_drain();

    rdy_mode = 3;
    send_row(5, 2, ROW);

    // R10: row cut short by a new start; only the restarted row appears
    send_row(6, 0, SKIP + 2);
    send_row(7, 0, ROW);
    wait_drain();
    @(negedge clk);
    check(ovf_err == 1'b0, "R7 no overflow in normal flow", int'(ovf_err), 0);
    @(posedge clk);
    #1;

    // R6 R7: block downstream, fill both slots, then offer a third row start
    rdy_mode = 2;
    idle(2);
    send_row(8, 0, ROW);
    @(negedge clk);
    check(in_ready == 1'b1, "R6 second slot free", int'(in_ready), 1);
    @(posedge clk);
    #1;
    send_row(9, 0, ROW);
    @(negedge clk);
    check(in_ready == 1'b0, "R6 both slots busy", int'(in_ready), 0);
    check(out_valid == 1'b1, "R6 first line still pending", int'(out_valid), 1);
    check(ovf_err == 1'b0, "R7 not yet raised", int'(ovf_err), 0);
    @(posedge clk);
    #1;
    in_valid = 1'b1;
    in_sol   = 1'b1;
    in_left  = PIX_W'(lval(10, 0));
    in_right = PIX_W'(rval(10, 0));
    @(negedge clk);
    check(in_ready == 1'b0, "R6 start refused", int'(in_ready), 0);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_sol   = 1'b0;
    @(negedge clk);
    check(ovf_err == 1'b1, "R7 overflow raised", int'(ovf_err), 1);
    @(posedge clk);
    #1;
    rdy_mode = 0;
    wait_drain();
    @(negedge clk);
    check(ovf_err == 1'b1, "R7 overflow sticky", int'(ovf_err), 1);
    check(in_ready == 1'b1, "R6 slots released", int'(in_ready), 1);
    check(out_valid == 1'b0, "R8 no extra output", int'(out_valid), 0);
    check(exp_q.size() == 0, "R4 all lines delivered", exp_q.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule